// File: doc/BRIEF.md
# SPI TPM Register Transaction Master

This block carries out a single register read or register write to a security-module device over SPI, including the wait-state flow control that such devices use. A client issues a request holding the direction, a byte count from 1 to 64 and a 24-bit register offset. The block adds the offset to the locality-zero base address 0xD40000 and then runs the whole transaction: a short wake pulse on chip select, a four-byte header, stall polling, and the data phase. When the transaction ends it pulses `done`, and on a stall timeout it also raises `err`.

Write data enters one byte at a time through a valid/ready handshake. Read data leaves the same way, and its final byte carries a last marker. The serial side runs in SPI mode 0, with the clock rate set by an elaboration-time divider. Every time interval is counted in system clock cycles. The defaults match a 50 MHz clock: a 1 µs wake low, a 100 µs wake high and a 100 ms stall limit. A test environment can scale these intervals down.

Top module: `tpm_spi_xact`

## Requirements
- R1: Header byte 0 is the first byte sent after the wake gap. Its bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 equal `req_len_m1`, which is the byte count minus one.
- R2: Header bytes 1, 2 and 3 carry the 24-bit sum 0xD40000 + `req_offset` (wrapping modulo 2^24), most significant byte first.
- R3: After a request is accepted, `spi_cs_n` is low for exactly WAKE_LOW_CYC cycles and then high for exactly WAKE_HIGH_CYC cycles, with no SCK edges, before it falls for the header.
- R4: After the header, with `spi_cs_n` still low, the block clocks out 0x00 bytes one at a time. It stops after the first received byte whose bit 0 (the last bit clocked in) is 1, and the data bytes follow directly. At least one poll byte is always sent.
- R5: If a poll byte completes with bit 0 equal to 0 after STALL_TMO_CYC cycles of polling have passed, the block deasserts `spi_cs_n` and sends no data bytes. The transaction then ends with `err` high in the `done` cycle, and a write accepts no write data.
- R6: A read that times out still delivers its full byte count on the read stream. Every byte is 0x00, and `rd_last` is set on the final byte.
- R7: For a write, the data bytes are taken through `wr_valid`/`wr_ready` in order. Each byte is transferred on a cycle with both signals high, and it is sent MSB first in the data phase.
- R8: For a read, each received data byte is presented on `rd_data` with `rd_valid`. It is held stable until `rd_ready` accepts it, and `rd_last` is high only on the final byte.
- R9: `spi_cs_n` returns high after the final data byte. `done` pulses for one cycle with `spi_cs_n` high, and `err` is low on a transaction that completes without timeout.
- R10: The serial link uses SPI mode 0. SCK is low whenever it is idle or chip select is high. Each SCK high phase lasts exactly CLK_DIV cycles, and MOSI changes only while SCK is low.
- R11: `req_ready` is high only while no transaction is running. A request held on the inputs during a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_len_m1 | input | 6 | Byte count minus one |
| req_offset | input | 24 | Register offset from the locality-zero base |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken this cycle |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final read byte of the transaction |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Stall timeout, valid with done |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Reads and writes are swept over byte counts from 1 to 64, including both field ends. The device model's stall length rotates from zero to three extra poll bytes, which separates a correct poll loop from one that leaves after a fixed count or checks the wrong bit. Offsets that wrap past the top of the 24-bit space test the address adder and the byte order. Stalls that never release, for both a read and a write, exercise the timeout exit and the zero-filled read stream. Stuttering valid/ready handshakes and a request held through a busy transaction show that data order and the single acceptance do not depend on client timing.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;

    localparam logic [23:0] LOC0_BASE = 24'hD40000;
    localparam int          HDR_BYTES = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAKE_LO,
        S_WAKE_HI,
        S_HDR,
        S_POLL,
        S_DATA,
        S_RDOUT,
        S_ZERO,
        S_FIN
    } seq_state_e;

    typedef struct packed {
        logic        rd;
        logic [5:0]  len_m1;
        logic [23:0] addr;
    } xact_req_t;

    function automatic logic [7:0] hdr_byte(xact_req_t r, logic [1:0] sel);
        case (sel)
            2'd0:    return {r.rd, 1'b1, r.len_m1};
            2'd1:    return r.addr[23:16];
            2'd2:    return r.addr[15:8];
            default: return r.addr[7:0];
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tpm_spi_timer.sv
module tpm_spi_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/tpm_spi_shifter.sv
module tpm_spi_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       done,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    txsr;
    logic [7:0]    rxsr;
    logic          busy;
    logic          sck_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            bitn   <= '0;
            txsr   <= '0;
            rxsr   <= '0;
            busy   <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    txsr <= tx_byte;
                    cnt  <= '0;
                    bitn <= '0;
                end
            end else if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rxsr  <= {rxsr[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy   <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        txsr <= {txsr[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign rx_byte = rxsr;
    assign done    = done_q;
    assign sck     = sck_q;
    assign mosi    = txsr[7];

    // R10: data out is held for the whole SCK high phase
    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (rst)
        sck_q |-> $stable(mosi));

    // R10: a byte ends with SCK low
    p_done_sck_low_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !sck_q);

endmodule

// File: rtl/tpm_spi_xact.sv
module tpm_spi_xact
    import tpm_spi_pkg::*;
#(
    parameter int          CLK_DIV       = 4,
    parameter int          WAKE_LOW_CYC  = 50,
    parameter int          WAKE_HIGH_CYC = 5000,
    parameter int          STALL_TMO_CYC = 5000000,
    parameter logic [23:0] BASE_ADDR     = LOC0_BASE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_read,
    input  logic [5:0]  req_len_m1,
    input  logic [23:0] req_offset,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [7:0]  rd_data,
    output logic        rd_last,
    output logic        done,
    output logic        err,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int TMR_MAX = max3(WAKE_LOW_CYC, WAKE_HIGH_CYC, STALL_TMO_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] LD_WLO = TMR_W'(WAKE_LOW_CYC - 1);
    localparam logic [TMR_W-1:0] LD_WHI = TMR_W'(WAKE_HIGH_CYC - 1);
    localparam logic [TMR_W-1:0] LD_TMO = TMR_W'(STALL_TMO_CYC - 1);
    localparam logic [5:0]       HDR_LAST = 6'(HDR_BYTES - 1);

    seq_state_e  st;
    xact_req_t   rq;
    logic [5:0]  idx;
    logic        inflight;
    logic        err_q;
    logic [7:0]  rbuf;

    logic             sh_start;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;
    logic             sh_done;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             at_last;

    assign at_last = (idx == rq.len_m1);

    tpm_spi_shifter #(.DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .rx_byte (sh_rx),
        .done    (sh_done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    tpm_spi_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        wr_ready = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_WLO;
                end
            end
            S_WAKE_LO: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_WHI;
                end
            end
            S_HDR: begin
                sh_start = !inflight;
                sh_tx    = hdr_byte(rq, idx[1:0]);
                if (sh_done && idx == HDR_LAST) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_TMO;
                end
            end
            S_POLL: begin
                sh_start = !inflight;
            end
            S_DATA: begin
                if (rq.rd) begin
                    sh_start = !inflight;
                end else begin
                    wr_ready = !inflight;
                    sh_start = !inflight && wr_valid;
                    sh_tx    = wr_data;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            rq       <= '0;
            idx      <= '0;
            inflight <= 1'b0;
            err_q    <= 1'b0;
            rbuf     <= '0;
        end else begin
            if (sh_start) begin
                inflight <= 1'b1;
            end else if (sh_done) begin
                inflight <= 1'b0;
            end
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        rq.rd     <= req_read;
                        rq.len_m1 <= req_len_m1;
                        rq.addr   <= BASE_ADDR + req_offset;
                        err_q     <= 1'b0;
                        st        <= S_WAKE_LO;
                    end
                end
                S_WAKE_LO: if (tmr_exp) st <= S_WAKE_HI;
                S_WAKE_HI: begin
                    if (tmr_exp) begin
                        idx <= '0;
                        st  <= S_HDR;
                    end
                end
                S_HDR: begin
                    if (sh_done) begin
                        if (idx == HDR_LAST) begin
                            idx <= '0;
                            st  <= S_POLL;
                        end else begin
                            idx <= idx + 6'd1;
                        end
                    end
                end
                S_POLL: begin
                    if (sh_done) begin
                        if (sh_rx[0]) begin
                            st <= S_DATA;
                        end else if (tmr_exp) begin
                            err_q <= 1'b1;
                            st    <= rq.rd ? S_ZERO : S_FIN;
                        end
                    end
                end
                S_DATA: begin
                    if (sh_done) begin
                        if (rq.rd) begin
                            rbuf <= sh_rx;
                            st   <= S_RDOUT;
                        end else if (at_last) begin
                            st <= S_FIN;
                        end else begin
                            idx <= idx + 6'd1;
                        end
                    end
                end
                S_RDOUT: begin
                    if (rd_ready) begin
                        if (at_last) begin
                            st <= S_FIN;
                        end else begin
                            idx <= idx + 6'd1;
                            st  <= S_DATA;
                        end
                    end
                end
                S_ZERO: begin
                    if (rd_ready) begin
                        if (at_last) st <= S_FIN;
                        else         idx <= idx + 6'd1;
                    end
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st == S_IDLE);
    assign spi_cs_n  = !(st == S_WAKE_LO || st == S_HDR || st == S_POLL ||
                         st == S_DATA || st == S_RDOUT);
    assign rd_valid  = (st == S_RDOUT) || (st == S_ZERO);
    assign rd_data   = (st == S_RDOUT) ? rbuf : 8'h00;
    assign rd_last   = rd_valid && at_last;
    assign done      = (st == S_FIN);
    assign err       = done && err_q;

    // R9: the end pulse only appears with the device deselected
    p_done_cs_high_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n);

    // R5: an unreleased stall past the limit drops chip select next cycle
    p_tmo_release_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_POLL && sh_done && !sh_rx[0] && tmr_exp) |=> spi_cs_n);

    // R6: read bytes offered while deselected are zero-filled
    p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && spi_cs_n) |-> (rd_data == 8'h00));

    // R8: an offered read byte is held until taken
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

    // R10: no clocking while chip select is high
    p_sck_idle_r10: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R11: readiness implies an idle link
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (spi_cs_n && !rd_valid && !wr_ready));

endmodule

// File: tb/tpm_spi_xact_tb.sv
module tpm_spi_xact_tb;
    localparam int DIV = 2;
    localparam int WL  = 3;
    localparam int WH  = 5;
    localparam int TMO = 150;
    localparam int NEVER = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [5:0]  req_len_m1 = '0;
    logic [23:0] req_offset = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_last;
    logic        done;
    logic        err;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso;

    always #10 clk = ~clk;

    tpm_spi_xact #(
        .CLK_DIV(DIV), .WAKE_LOW_CYC(WL), .WAKE_HIGH_CYC(WH), .STALL_TMO_CYC(TMO)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_len_m1(req_len_m1), .req_offset(req_offset),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
        .done(done), .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(int d, int s);
        return 8'((d * 29 + s) & 255);
    endfunction

    function automatic logic [7:0] wpat(int d, int s);
        return 8'((d * 53 + s + 7) & 255);
    endfunction

    // device model: mode 0 target with wait-state polling
    int dev_stall = 0;
    int dev_seed  = 0;
    int bitc = 0;
    int bytec = 0;
    logic [7:0] shin = '0;
    logic [7:0] cap [0:255];
    logic miso_q = 1'b0;

    function automatic logic [7:0] dev_byte(int b);
        if (b < 4 + dev_stall) return 8'h00;
        if (b == 4 + dev_stall) return 8'h01;
        return rpat(b - 5 - dev_stall, dev_seed);
    endfunction

    always @(negedge spi_cs_n) begin
        bitc  = 0;
        bytec = 0;
        miso_q = 1'b0;
    end

    always @(posedge spi_sck) begin
        shin = {shin[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (bytec < 256) cap[bytec] = shin;
            bytec++;
            bitc = 0;
        end
    end

    always @(negedge spi_sck) begin
        logic [7:0] t;
        t = dev_byte(bytec);
        miso_q = t[7 - bitc];
    end

    assign spi_miso = miso_q;

    // link monitors for R10
    int hi_run = 0, hi_min = 1000, hi_max = 0, mosi_bad = 0, sck_bad = 0;
    logic prev_sck = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sck) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_bad++;
            if (spi_cs_n && spi_sck) sck_bad++;
        end
        prev_sck  = spi_sck;
        prev_mosi = spi_mosi;
    end

    int cyc_all = 0;
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", cyc_all, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_txn(input bit rd, input int len, input int off, input int stall,
                           input int seed, input bit gappy, input bit hold_req);
        int lo, hi, rdy_busy, wr_seen, got_rd;
        bit got_err, got_cs, tmo;
        logic [23:0] addr;
        tmo = (stall >= NEVER);
        dev_stall = stall;
        dev_seed  = seed;
        rdy_busy = 0;
        wr_seen  = 0;
        got_rd   = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_read   = rd;
        req_len_m1 = 6'(len - 1);
        req_offset = 24'(off);
        chk(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        if (hold_req) begin
            req_read   = !rd;
            req_offset = ~24'(off);
        end else begin
            req_valid = 1'b0;
        end
        lo = 0;
        while (spi_cs_n == 1'b0) begin
            lo++;
            if (req_ready) rdy_busy++;
            @(negedge clk);
        end
        hi = 0;
        while (spi_cs_n == 1'b1) begin
            hi++;
            if (req_ready) rdy_busy++;
            @(negedge clk);
        end
        chk(lo == WL, "R3 wake low cycles", lo, WL);
        chk(hi == WH, "R3 wake high cycles", hi, WH);
        fork
            begin
                if (!rd && !tmo) begin
                    int i, c;
                    i = 0;
                    c = 0;
                    while (i < len) begin
                        wr_valid = !(gappy && (c % 3 == 1));
                        wr_data  = wpat(i, seed);
                        if (wr_valid && wr_ready) i++;
                        c++;
                        @(negedge clk);
                    end
                    wr_valid = 1'b0;
                end
            end
            begin
                if (rd) begin
                    int i, c;
                    logic [7:0] e;
                    i = 0;
                    c = 0;
                    while (i < len) begin
                        rd_ready = !(gappy && (c % 3 == 1));
                        if (rd_valid && rd_ready) begin
                            e = tmo ? 8'h00 : rpat(i, seed);
                            if (tmo) chk(rd_data == e, "R6 zero read data", int'(rd_data), int'(e));
                            else     chk(rd_data == e, "R8 read data", int'(rd_data), int'(e));
                            chk(rd_last == (i == len - 1), "R8 last marker", int'(rd_last), int'(i == len - 1));
                            i++;
                            got_rd++;
                        end
                        c++;
                        @(negedge clk);
                    end
                    rd_ready = 1'b0;
                end
            end
            begin
                while (!done) begin
                    if (req_ready) rdy_busy++;
                    if (wr_ready) wr_seen++;
                    @(negedge clk);
                end
                got_err = err;
                got_cs  = spi_cs_n;
                req_valid = 1'b0;
            end
        join
        chk(got_err == tmo, "R5 R9 err flag", int'(got_err), int'(tmo));
        chk(got_cs == 1'b1, "R9 cs high at done", int'(got_cs), 1);
        chk(cap[0] == {rd, 1'b1, 6'(len - 1)}, "R1 header byte 0", int'(cap[0]),
            int'({rd, 1'b1, 6'(len - 1)}));
        addr = 24'hD40000 + 24'(off);
        chk({cap[1], cap[2], cap[3]} == addr, "R2 address bytes",
            int'({cap[1], cap[2], cap[3]}), int'(addr));
        if (!tmo) begin
            chk(bytec == 5 + stall + len, "R4 byte count", bytec, 5 + stall + len);
            for (int k = 4; k <= 4 + stall; k++)
                chk(cap[k] == 8'h00, "R4 poll byte zero", int'(cap[k]), 0);
            if (!rd)
                for (int k = 0; k < len; k++)
                    chk(cap[5 + stall + k] == wpat(k, seed), "R7 write data",
                        int'(cap[5 + stall + k]), int'(wpat(k, seed)));
        end else begin
            chk(bytec >= 4 + TMO / (16 * DIV) && bytec <= 6 + TMO / (16 * DIV),
                "R5 poll count", bytec - 4, TMO / (16 * DIV) + 1);
            if (rd) chk(got_rd == len, "R6 zero byte count", got_rd, len);
            else    chk(wr_seen == 0, "R5 no write data taken", wr_seen, 0);
        end
        chk(rdy_busy == 0, "R11 ready low while busy", rdy_busy, 0);
        repeat (4) @(negedge clk);
        if (hold_req) begin
            chk(spi_cs_n == 1'b1 && req_ready == 1'b1, "R11 held request ignored",
                int'(req_ready), 1);
        end
    endtask

    initial begin
        int lens [9] = '{1, 2, 3, 5, 8, 17, 32, 63, 64};
        int offs [9] = '{24'h000000, 24'h000018, 24'h000024, 24'h000F00, 24'h2BFFFF,
                         24'h2C0004, 24'h123456, 24'h0000F9, 24'h3FFFFF};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10 reset link idle", int'(spi_cs_n), 1);
        chk(req_ready == 1'b1 && done == 1'b0 && rd_valid == 1'b0, "R11 reset ready",
            int'(req_ready), 1);
        for (int k = 0; k < 9; k++) begin
            run_txn(1'b1, lens[k], offs[k], k % 4, k * 11 + 3, k[0], 1'b0);
            run_txn(1'b0, lens[k], offs[8 - k], (k + 2) % 4, k * 7 + 1, !k[0], 1'b0);
        end
        run_txn(1'b1, 4, 24'h000024, NEVER, 5, 1'b0, 1'b0);
        run_txn(1'b0, 3, 24'h000018, NEVER, 9, 1'b0, 1'b0);
        run_txn(1'b1, 2, 24'h000F04, 1, 13, 1'b0, 1'b1);
        chk(hi_min == DIV && hi_max == DIV, "R10 SCK high phase", hi_max, DIV);
        chk(mosi_bad == 0, "R10 MOSI stable while SCK high", mosi_bad, 0);
        chk(sck_bad == 0, "R10 SCK low while deselected", sck_bad, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule